// File: doc/BRIEF.md
# PWM Dead-Time Insertion Unit

This block sits between a PWM compare stage and the output drivers of three half-bridge legs. Each leg has a raw compare-state bit. From it the block forms a true output and a complementary output. When the compare state changes, the output that is about to turn on is held off for a programmable number of clocks. The output that is turning off drops at once. The two switches of a leg are therefore never driven on together, and there is a guard interval between one switching off and the other switching on.

All legs share one dead-time count. Each leg has its own enable bit and its own down counter, so legs switching at different moments are timed apart from each other. A leg whose enable is low bypasses the delay and simply registers its compare state. Each leg reports a run flag while its counter is still counting.

Top module: `dtu_deadtime`

## Requirements
- R1: While `rst` is high at a rising clock edge, every `out_true`, `out_comp` and `dt_run` bit is 0 after that edge.
- R2: On an enabled leg, a 0-to-1 change of `cmp_state` drives `out_comp` low after the first clock edge that sees it. `out_true` rises only after `dt_value` further edges.
- R3: On an enabled leg, a 1-to-0 change of `cmp_state` drives `out_true` low after the first edge that sees it. `out_comp` rises only after `dt_value` further edges.
- R4: A leg's `dt_run` bit is 1 after each of the `dt_value` edges that start with the edge seeing the change, and 0 from the edge on which the delayed output turns on.
- R5: With `dt_value` equal to 0, an enabled leg has no delay: `out_true` equals, and `out_comp` inverts, the compare state seen at the previous edge, and `dt_run` stays 0.
- R6: A leg whose `dt_enable` bit is 0 ignores `dt_value`: its outputs follow the compare state one edge later and its `dt_run` bit stays 0.
- R7: If the compare state of an enabled leg changes again while its counter is non-zero, the count restarts from `dt_value`, and both outputs of that leg stay low until the new count expires.
- R8: Each leg counts on its own, so a change on one leg does not alter the timing or outputs of another.
- R9: `out_true` and `out_comp` of one leg are never 1 together.
- R10: `dt_value` is read only at the edge that starts a count. Changing it during a count does not shorten or lengthen that count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dt_value | input | DT_W (8) | Shared dead-time length in clocks |
| dt_enable | input | CHANNELS (3) | Per-leg delay enable, bit i for leg i |
| cmp_state | input | CHANNELS (3) | Raw compare state per leg |
| out_true | output | CHANNELS (3) | Delayed true output per leg |
| out_comp | output | CHANNELS (3) | Delayed complementary output per leg |
| dt_run | output | CHANNELS (3) | High while the leg's dead-time counter is non-zero |

## Verification
Suppose a compare-state change is applied before edge k. The turning-off output and the start of `dt_run` are then due right after edge k. The turning-on output and the fall of `dt_run` are due right after edge k+`dt_value`. A disabled leg, or a zero count, responds right after edge k alone. The bench changes its inputs just after a falling edge and reads the outputs at the next falling edge, so each read shows the result of exactly one rising edge. Each scenario checks every intermediate read of a count as well as the first read in which the delayed output turns on, which catches results that arrive one cycle early or one cycle late.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

    localparam int unsigned DTU_DT_W_DEF = 8;
    localparam int unsigned DTU_CH_DEF   = 3;

    typedef struct packed {
        logic rise;
        logic fall;
    } dtu_edge_t;

endpackage

// File: rtl/dtu_edge_detect.sv
module dtu_edge_detect
    import dtu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      level_i,
    output dtu_edge_t edge_o
);

    typedef struct packed {
        logic prev;
    } ed_state_t;

    ed_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.prev   = level_i;
        edge_o.rise = level_i & ~s_q.prev;
        edge_o.fall = ~level_i & s_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

endmodule

// File: rtl/dtu_down_counter.sv
module dtu_down_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         clear_i,
    output logic [W-1:0] count_o,
    output logic         busy_o,
    output logic         zero_next_o
);

    typedef struct packed {
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i)
            s_d.count = '0;
        else if (load_i)
            s_d.count = load_val_i;
        else if (s_q.count != '0)
            s_d.count = s_q.count - 1'b1;
        count_o     = s_q.count;
        busy_o      = (s_q.count != '0);
        zero_next_o = (s_d.count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R10: the value in place at the load edge is what gets counted
    assert_reload_R10: assert property (@(posedge clk) disable iff (rst)
        (load_i && !clear_i) |=> (count_o == $past(load_val_i)));

    // R4: one decrement per clock while running and undisturbed
    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !clear_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

    // R6: clearing empties the counter
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (count_o == '0));

endmodule

// File: rtl/dtu_channel.sv
module dtu_channel
    import dtu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable_i,
    input  logic         level_i,
    input  logic [W-1:0] dt_value_i,
    output logic         out_true_o,
    output logic         out_comp_o,
    output logic         run_o
);

    typedef struct packed {
        logic true_out;
        logic comp_out;
    } ch_state_t;

    ch_state_t    s_d, s_q;
    dtu_edge_t    lvl_edge;
    logic         load;
    logic         clear;
    logic         zero_next;
    logic         busy;
    logic [W-1:0] count;

    dtu_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (level_i),
        .edge_o  (lvl_edge)
    );

    assign load  = enable_i & (lvl_edge.rise | lvl_edge.fall);
    assign clear = ~enable_i;

    dtu_down_counter #(.W(W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .load_val_i  (dt_value_i),
        .clear_i     (clear),
        .count_o     (count),
        .busy_o      (busy),
        .zero_next_o (zero_next)
    );

    always_comb begin
        s_d          = s_q;
        s_d.true_out = level_i & zero_next;
        s_d.comp_out = ~level_i & zero_next;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_true_o = s_q.true_out;
    assign out_comp_o = s_q.comp_out;
    assign run_o      = busy;

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        !(out_true_o && out_comp_o));

    // R7: both switches of the leg are off while a count is running
    assert_passive_while_run_R7: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> (!out_true_o && !out_comp_o));

    assert_fast_off_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(level_i) |=> !out_comp_o);

    assert_fast_off_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(level_i) |=> !out_true_o);

    assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (out_true_o == $past(level_i) && !run_o));

endmodule

// File: rtl/dtu_deadtime.sv
module dtu_deadtime
    import dtu_pkg::*;
#(
    parameter int unsigned DT_W     = DTU_DT_W_DEF,
    parameter int unsigned CHANNELS = DTU_CH_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DT_W-1:0]     dt_value,
    input  logic [CHANNELS-1:0] dt_enable,
    input  logic [CHANNELS-1:0] cmp_state,
    output logic [CHANNELS-1:0] out_true,
    output logic [CHANNELS-1:0] out_comp,
    output logic [CHANNELS-1:0] dt_run
);

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        dtu_channel #(.W(DT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .enable_i   (dt_enable[i]),
            .level_i    (cmp_state[i]),
            .dt_value_i (dt_value),
            .out_true_o (out_true[i]),
            .out_comp_o (out_comp[i]),
            .run_o      (dt_run[i])
        );
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (out_true == '0 && out_comp == '0 && dt_run == '0));

endmodule

// File: tb/dtu_deadtime_tb.sv
module dtu_deadtime_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CH = 3;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  dt_value;
    logic [CH-1:0] dt_enable;
    logic [CH-1:0] cmp_state;
    logic [CH-1:0] out_true;
    logic [CH-1:0] out_comp;
    logic [CH-1:0] dt_run;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtu_deadtime #(.DT_W(W), .CHANNELS(CH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .dt_value  (dt_value),
        .dt_enable (dt_enable),
        .cmp_state (cmp_state),
        .out_true  (out_true),
        .out_comp  (out_comp),
        .dt_run    (dt_run)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [CH-1:0] act, logic [CH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(string req, logic [CH-1:0] t, logic [CH-1:0] c, logic [CH-1:0] r);
        chk(req, "out_true", out_true, t);
        chk(req, "out_comp", out_comp, c);
        chk(req, "dt_run", dt_run, r);
        chk("R9", "overlap", out_true & out_comp, '0);
    endtask

    task automatic t_reset();
        rst = 1'b1; dt_value = 8'd4; dt_enable = '1; cmp_state = '0;
        step(); step();
        chk_all("R1", 3'b000, 3'b000, 3'b000);
        rst = 1'b0;
        step();
        chk_all("R1", 3'b000, 3'b111, 3'b000);
    endtask

    task automatic t_rise();
        cmp_state[0] = 1'b1;
        for (int j = 0; j < 4; j++) begin
            step();
            chk_all("R2", 3'b000, 3'b110, 3'b001);
        end
        step();
        chk_all("R4", 3'b001, 3'b110, 3'b000);
    endtask

    task automatic t_fall();
        cmp_state[0] = 1'b0;
        for (int j = 0; j < 4; j++) begin
            step();
            chk_all("R3", 3'b000, 3'b110, 3'b001);
        end
        step();
        chk_all("R4", 3'b000, 3'b111, 3'b000);
    endtask

    task automatic t_zero();
        dt_value = 8'd0;
        cmp_state[0] = 1'b1;
        step();
        chk_all("R5", 3'b001, 3'b110, 3'b000);
        cmp_state[0] = 1'b0;
        step();
        chk_all("R5", 3'b000, 3'b111, 3'b000);
        dt_value = 8'd4;
    endtask

    task automatic t_disabled();
        dt_enable[1] = 1'b0;
        cmp_state[1] = 1'b1;
        step();
        chk_all("R6", 3'b010, 3'b101, 3'b000);
        cmp_state[1] = 1'b0;
        step();
        chk_all("R6", 3'b000, 3'b111, 3'b000);
        dt_enable[1] = 1'b1;
        step();
        chk_all("R6", 3'b000, 3'b111, 3'b000);
    endtask

    task automatic t_retoggle();
        cmp_state[2] = 1'b1;
        step(); chk_all("R7", 3'b000, 3'b011, 3'b100);
        step(); chk_all("R7", 3'b000, 3'b011, 3'b100);
        cmp_state[2] = 1'b0;
        for (int j = 0; j < 4; j++) begin
            step();
            chk_all("R7", 3'b000, 3'b011, 3'b100);
        end
        step();
        chk_all("R7", 3'b000, 3'b111, 3'b000);
    endtask

    task automatic t_independent();
        dt_value = 8'd3;
        cmp_state[1] = 1'b1;
        step(); chk_all("R8", 3'b000, 3'b101, 3'b010);
        step(); chk_all("R8", 3'b000, 3'b101, 3'b010);
        cmp_state[2] = 1'b1;
        step(); chk_all("R8", 3'b000, 3'b001, 3'b110);
        step(); chk_all("R8", 3'b010, 3'b001, 3'b100);
        step(); chk_all("R8", 3'b010, 3'b001, 3'b100);
        step(); chk_all("R8", 3'b110, 3'b001, 3'b000);
        cmp_state = '0;
        for (int j = 0; j < 4; j++) step();
        chk_all("R8", 3'b000, 3'b111, 3'b000);
    endtask

    task automatic t_dt_change();
        dt_value = 8'd5;
        cmp_state[0] = 1'b1;
        step();
        chk_all("R10", 3'b000, 3'b110, 3'b001);
        dt_value = 8'd1;
        for (int j = 0; j < 4; j++) begin
            step();
            chk_all("R10", 3'b000, 3'b110, 3'b001);
        end
        step();
        chk_all("R10", 3'b001, 3'b110, 3'b000);
    endtask

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_zero();
        t_disabled();
        t_retoggle();
        t_independent();
        t_dt_change();
        step();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule